// File: doc/BRIEF.md
# Order-Preserving Flagged-Entry Compactor

This block gathers candidate entries and packs them tightly. Each cycle it receives a set of replica entries plus one extra entry from a branch source. Each entry is a configuration word with a flag. The flagged entries move down into the lowest output slots. Their relative order never changes, so a lower slot always holds an older candidate, meaning one with a smaller start offset. The branch entry counts as the newest input, so it always lands after every flagged replica entry. This ordering lets the logic downstream pick leftmost matches by slot index alone.

Each entry's destination comes from a parallel prefix count of the flags. Every entry learns how many unflagged entries sit below it, and that number is how far it must slide down. A chain of log2 shift stages then moves the data. Stage k moves an entry down by 2^k when bit k of its displacement is set. Entries travel in order, so no two ever collide. The result is registered, which gives a latency of one clock cycle.

There are one more input entry than output slots. If every input is flagged, the branch entry has no slot. It is dropped, and a drop indicator is raised for that cycle.

Top module: `pack_order_net`

## Requirements
- R1: While `rst_n` is low, all load flags, all load configurations and `drop_o` are 0, whatever the inputs are.
- R2: Each output reflects the inputs sampled at the previous rising clock edge (latency of exactly one cycle).
- R3: The number of set load flags equals the number of flagged inputs, capped at SLOTS.
- R4: Set load flags are contiguous from slot 0: slot k is flagged only if every slot below k is flagged.
- R5: Slot k holds the configuration of the (k+1)-th flagged input. Inputs are taken in the order replica 0, replica 1, …, replica SLOTS−1, then branch.
- R6: A flagged branch entry lands in the slot just after the last flagged replica entry, and never ahead of one.
- R7: The configuration of every slot whose load flag is 0 is all zeros.
- R8: When all SLOTS+1 inputs are flagged, the branch entry is discarded, the replica entries fill every slot in order, and `drop_o` is 1 for that one cycle. In every other cycle `drop_o` is 0.
- R9: The configuration value of an unflagged input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_cfg_i | input | SLOTS*CFG_W | Replica configurations, entry i in bits [i*CFG_W +: CFG_W] |
| act_flag_i | input | SLOTS | Replica flags, bit i for replica i |
| br_cfg_i | input | CFG_W | Branch configuration |
| br_flag_i | input | 1 | Branch flag |
| load_cfg_o | output | SLOTS*CFG_W | Packed configurations, slot k in bits [k*CFG_W +: CFG_W] |
| load_flag_o | output | SLOTS | Packed flags, bit k for slot k |
| drop_o | output | 1 | Branch entry was discarded for lack of a slot |

## Verification
The assertions check four properties on every cycle. The load flags must form a thermometer code. Every unflagged slot must carry a zero configuration. The flag population must follow the capped input count one cycle later. The drop indicator must follow the all-inputs-flagged condition one cycle later.

Slot contents and their order are left to the bench scenarios. These cover the placement of a branch behind scattered replica entries, the discard at full occupancy, and the insensitivity to unflagged configuration values. They also include the reset behaviour under active inputs and a long stream of pseudo-random flag patterns.

// File: rtl/pack_net_pkg.sv
package pack_net_pkg;

   // Number of shift stages needed to cover displacements up to entries-1.
   function automatic int stage_count(input int entries);
      if (entries <= 2) return 1;
      return $clog2(entries);
   endfunction

endpackage

// File: rtl/pack_prefix_scan.sv
// Exclusive prefix count of unflagged entries (Kogge-Stone style scan).
// disp_o[i] = number of unflagged entries with index below i.
module pack_prefix_scan #(
   parameter int ENTRIES = 8,
   parameter int DW      = 3
) (
   input  logic [ENTRIES-1:0]         flag_i,
   output logic [ENTRIES-1:0][DW-1:0] disp_o
);
   localparam int LEVELS = pack_net_pkg::stage_count(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pack_prefix_scan: ENTRIES must be at least 2");
   end
   if ((1 << DW) < ENTRIES) begin : g_bad_dw
      $error("pack_prefix_scan: DW too narrow for ENTRIES");
   end

   logic [ENTRIES-1:0][DW-1:0] lvl [0:LEVELS];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_seed
      if (i == 0) begin : g_first
         assign lvl[0][i] = '0;
      end else begin : g_rest
         assign lvl[0][i] = DW'(!flag_i[i-1]);
      end
   end

   for (genvar s = 0; s < LEVELS; s++) begin : g_level
      localparam int STRIDE = 1 << s;
      for (genvar i = 0; i < ENTRIES; i++) begin : g_node
         if (i >= STRIDE) begin : g_add
            assign lvl[s+1][i] = lvl[s][i] + lvl[s][i-STRIDE];
         end else begin : g_pass
            assign lvl[s+1][i] = lvl[s][i];
         end
      end
   end

   assign disp_o = lvl[LEVELS];

endmodule

// File: rtl/pack_shift_stage.sv
// One routing stage: entries whose displacement has bit BIT set move down
// by 2**BIT positions; the others stay. Order-preserving compaction
// guarantees that no two entries compete for one position.
module pack_shift_stage #(
   parameter int ENTRIES = 8,
   parameter int CW      = 8,
   parameter int DW      = 3,
   parameter int BIT     = 0
) (
   input  logic [ENTRIES-1:0]         v_i,
   input  logic [ENTRIES-1:0][CW-1:0] cfg_i,
   input  logic [ENTRIES-1:0][DW-1:0] d_i,
   output logic [ENTRIES-1:0]         v_o,
   output logic [ENTRIES-1:0][CW-1:0] cfg_o,
   output logic [ENTRIES-1:0][DW-1:0] d_o
);
   localparam int STRIDE = 1 << BIT;

   if (BIT >= DW) begin : g_bad_bit
      $error("pack_shift_stage: BIT out of displacement range");
   end

   for (genvar j = 0; j < ENTRIES; j++) begin : g_pos
      logic stay;
      logic take_hi;
      assign stay = v_i[j] && !d_i[j][BIT];
      if (j + STRIDE < ENTRIES) begin : g_upper
         assign take_hi = v_i[j+STRIDE] && d_i[j+STRIDE][BIT];
      end else begin : g_top
         assign take_hi = 1'b0;
      end

      always_comb begin
         v_o[j]   = 1'b0;
         cfg_o[j] = '0;
         d_o[j]   = '0;
         if (take_hi) begin
            v_o[j]   = 1'b1;
            cfg_o[j] = cfg_i[(j+STRIDE) % ENTRIES];
            d_o[j]   = d_i[(j+STRIDE) % ENTRIES];
         end else if (stay) begin
            v_o[j]   = 1'b1;
            cfg_o[j] = cfg_i[j];
            d_o[j]   = d_i[j];
         end
      end
   end

endmodule

// File: rtl/pack_order_net.sv
// Order-preserving compactor: SLOTS replica entries plus one branch entry
// (treated as newest) packed into SLOTS registered load slots.
module pack_order_net #(
   parameter int SLOTS = 7,
   parameter int CFG_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SLOTS-1:0][CFG_W-1:0] act_cfg_i,
   input  logic [SLOTS-1:0]            act_flag_i,
   input  logic [CFG_W-1:0]            br_cfg_i,
   input  logic                        br_flag_i,
   output logic [SLOTS-1:0][CFG_W-1:0] load_cfg_o,
   output logic [SLOTS-1:0]            load_flag_o,
   output logic                        drop_o
);
   localparam int ENTRIES = SLOTS + 1;
   localparam int DW      = pack_net_pkg::stage_count(ENTRIES);
   localparam int LEVELS  = DW;

   if (SLOTS < 1) begin : g_bad_slots
      $error("pack_order_net: SLOTS must be at least 1");
   end
   if (CFG_W < 1) begin : g_bad_cfg
      $error("pack_order_net: CFG_W must be at least 1");
   end

   logic [ENTRIES-1:0]            in_flag;
   logic [ENTRIES-1:0][CFG_W-1:0] in_cfg;
   logic [ENTRIES-1:0][DW-1:0]    disp;

   // Branch occupies the highest input position: it is the newest candidate.
   assign in_flag = {br_flag_i, act_flag_i};

   for (genvar i = 0; i < ENTRIES; i++) begin : g_mask
      if (i < SLOTS) begin : g_act
         assign in_cfg[i] = act_flag_i[i] ? act_cfg_i[i] : '0;
      end else begin : g_br
         assign in_cfg[i] = br_flag_i ? br_cfg_i : '0;
      end
   end

   pack_prefix_scan #(
      .ENTRIES (ENTRIES),
      .DW      (DW)
   ) i_scan (
      .flag_i (in_flag),
      .disp_o (disp)
   );

   logic [ENTRIES-1:0]            st_v   [0:LEVELS];
   logic [ENTRIES-1:0][CFG_W-1:0] st_cfg [0:LEVELS];
   logic [ENTRIES-1:0][DW-1:0]    st_d   [0:LEVELS];

   assign st_v[0]   = in_flag;
   assign st_cfg[0] = in_cfg;
   assign st_d[0]   = disp;

   for (genvar s = 0; s < LEVELS; s++) begin : g_stage
      pack_shift_stage #(
         .ENTRIES (ENTRIES),
         .CW      (CFG_W),
         .DW      (DW),
         .BIT     (s)
      ) i_shift (
         .v_i   (st_v[s]),
         .cfg_i (st_cfg[s]),
         .d_i   (st_d[s]),
         .v_o   (st_v[s+1]),
         .cfg_o (st_cfg[s+1]),
         .d_o   (st_d[s+1])
      );
   end

   logic [SLOTS-1:0][CFG_W-1:0] nxt_cfg;
   logic [SLOTS-1:0]            nxt_flag;
   logic                        nxt_drop;

   assign nxt_flag = st_v[LEVELS][SLOTS-1:0];
   assign nxt_cfg  = st_cfg[LEVELS][SLOTS-1:0];
   // Only a full set of flags leaves an entry in the spare top position.
   assign nxt_drop = st_v[LEVELS][SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_cfg_o  <= '0;
         load_flag_o <= '0;
         drop_o      <= 1'b0;
      end else begin
         load_cfg_o  <= nxt_cfg;
         load_flag_o <= nxt_flag;
         drop_o      <= nxt_drop;
      end
   end

endmodule

// File: rtl/pack_order_net_chk.sv
module pack_order_net_chk #(
   parameter int SLOTS = 7,
   parameter int CFG_W = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [SLOTS-1:0]            act_flag_i,
   input logic                        br_flag_i,
   input logic [SLOTS-1:0][CFG_W-1:0] load_cfg_o,
   input logic [SLOTS-1:0]            load_flag_o,
   input logic                        drop_o
);
   function automatic int capped(input int n);
      return (n > SLOTS) ? SLOTS : n;
   endfunction

   logic stray_cfg;
   always_comb begin
      stray_cfg = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
         if (!load_flag_o[k] && (load_cfg_o[k] != '0)) stray_cfg = 1'b1;
      end
   end

   // R4
   thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((load_flag_o & (load_flag_o + 1'b1)) == '0));

   // R7
   empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stray_cfg);

   // R3
   flag_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(load_flag_o) ==
                capped($countones({$past(br_flag_i), $past(act_flag_i)}))));

   // R8
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_o == ($past(br_flag_i) && (&$past(act_flag_i)))));

endmodule

bind pack_order_net pack_order_net_chk #(
   .SLOTS (SLOTS),
   .CFG_W (CFG_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .act_flag_i  (act_flag_i),
   .br_flag_i   (br_flag_i),
   .load_cfg_o  (load_cfg_o),
   .load_flag_o (load_flag_o),
   .drop_o      (drop_o)
);

// File: tb/test_pack_order_net.sv
`timescale 1ns/1ps
module test_pack_order_net;
   localparam int SLOTS = 7;
   localparam int CFG_W = 8;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic [SLOTS-1:0][CFG_W-1:0] act_cfg_i = '0;
   logic [SLOTS-1:0]            act_flag_i = '0;
   logic [CFG_W-1:0]            br_cfg_i = '0;
   logic                        br_flag_i = 1'b0;
   logic [SLOTS-1:0][CFG_W-1:0] load_cfg_o;
   logic [SLOTS-1:0]            load_flag_o;
   logic                        drop_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pack_order_net #(.SLOTS(SLOTS), .CFG_W(CFG_W)) i_pack_order_net (
      .clk(clk), .rst_n(rst_n),
      .act_cfg_i(act_cfg_i), .act_flag_i(act_flag_i),
      .br_cfg_i(br_cfg_i), .br_flag_i(br_flag_i),
      .load_cfg_o(load_cfg_o), .load_flag_o(load_flag_o), .drop_o(drop_o)
   );

   // Scoreboard queues
   logic [SLOTS-1:0]            q_flag [$];
   logic [SLOTS-1:0][CFG_W-1:0] q_cfg  [$];
   logic                        q_drop [$];
   string                       q_tag  [$];

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: drive at the falling edge, push the expected result.
   task automatic apply(input logic [SLOTS-1:0] af, input logic [SLOTS-1:0][CFG_W-1:0] ac,
                        input logic bf, input logic [CFG_W-1:0] bc, input string tag);
      logic [SLOTS-1:0]            ef;
      logic [SLOTS-1:0][CFG_W-1:0] ec;
      logic                        ed;
      int                          k;
      @(negedge clk);
      act_flag_i = af; act_cfg_i = ac; br_flag_i = bf; br_cfg_i = bc;
      ef = '0; ec = '0; ed = 1'b0; k = 0;
      for (int i = 0; i < SLOTS; i++) begin
         if (af[i]) begin ef[k] = 1'b1; ec[k] = ac[i]; k++; end
      end
      if (bf) begin
         if (k < SLOTS) begin ef[k] = 1'b1; ec[k] = bc; end
         else ed = 1'b1;
      end
      q_flag.push_back(ef); q_cfg.push_back(ec); q_drop.push_back(ed); q_tag.push_back(tag);
   endtask

   // Monitor: one cycle after each push the registered result is compared.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_flag.size() > 0) begin
            logic [SLOTS-1:0]            ef;
            logic [SLOTS-1:0][CFG_W-1:0] ec;
            logic                        ed;
            string                       tg;
            ef = q_flag.pop_front(); ec = q_cfg.pop_front();
            ed = q_drop.pop_front(); tg = q_tag.pop_front();
            check({tg, " R2 flags"}, 64'(load_flag_o), 64'(ef));
            check({tg, " R5 cfg"}, 64'(load_cfg_o), 64'(ec));
            check({tg, " R8 drop"}, 64'(drop_o), 64'(ed));
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [SLOTS-1:0][CFG_W-1:0] seq_cfg(input int base);
      logic [SLOTS-1:0][CFG_W-1:0] r;
      for (int i = 0; i < SLOTS; i++) r[i] = CFG_W'(base + i + 1);
      return r;
   endfunction

   initial begin
      logic [15:0] lfsr;
      // R1: reset holds outputs at zero even with all inputs active
      act_flag_i = '1; act_cfg_i = seq_cfg(8'h30); br_flag_i = 1'b1; br_cfg_i = 8'hBB;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset flags", 64'(load_flag_o), 64'd0);
      check("R1 reset cfg", 64'(load_cfg_o), 64'd0);
      check("R1 reset drop", 64'(drop_o), 64'd0);
      @(negedge clk);
      act_flag_i = '0; br_flag_i = 1'b0;
      rst_n = 1'b1;

      apply('0, seq_cfg(8'h10), 1'b0, 8'h55, "R3 none flagged");
      apply('1, seq_cfg(8'h20), 1'b0, 8'h55, "R3 all replicas");
      apply(7'b1010101, seq_cfg(8'h40), 1'b0, 8'h00, "R5 alternating");
      apply(7'b0000000, seq_cfg(8'h50), 1'b1, 8'hA5, "R6 branch only");
      apply(7'b1000010, seq_cfg(8'h60), 1'b1, 8'hC3, "R6 branch after scattered");
      apply('1, seq_cfg(8'h70), 1'b1, 8'hEE, "R8 full discard");
      apply(7'b0111111, seq_cfg(8'h70), 1'b1, 8'hEE, "R8 one gap no discard");
      apply(7'b0010010, {SLOTS{8'hFF}}, 1'b0, 8'h99, "R9 R7 unflagged noise a");
      apply(7'b0010010, {SLOTS{8'h00}} | (56'hFF << 8) | (56'hFF << 32), 1'b0, 8'h11, "R9 unflagged noise b");
      apply(7'b1000000, seq_cfg(8'h80), 1'b1, 8'h7E, "R5 top replica then branch");
      lfsr = 16'hACE1;
      for (int n = 0; n < 300; n++) begin
         logic [SLOTS-1:0][CFG_W-1:0] c;
         for (int i = 0; i < SLOTS; i++) c[i] = CFG_W'(lfsr ^ 16'(i * 37));
         apply(lfsr[SLOTS-1:0] | ((n % 9 == 0) ? '1 : '0), c, lfsr[9], lfsr[15:8], "R4 R5 random");
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      @(negedge clk);
      act_flag_i = '0; br_flag_i = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R3 queue drained", 64'(q_flag.size()), 64'd0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule